// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Mute

This block scales a stereo stream of 24-bit signed samples on the playback path. Each channel has its own 8-bit attenuation code in quarter-decibel steps. A shared master mute fades both channels out along a raised-cosine gain curve, and fades them back in along the same curve in reverse, so that muting never makes an audible step. An optional polarity flip negates both output channels.

Samples arrive with a one-cycle valid strobe. The control inputs are static, and the block samples them together with each accepted sample, so a control change only takes effect at a sample boundary. Each result leaves two clock cycles later with its own valid strobe. Between results the outputs hold their last value.

The attenuation is built from two factors. A right shift by one bit for every 24 codes gives 6.02 dB per shift. A 24-entry fractional mantissa table in Q1.15 covers the quarter-decibel steps within each shift. The cosine envelope is a 32-entry table, and each entry is held for four accepted samples, so a full fade takes 128 samples.

Top module: `stereo_vol_softmute`

## Requirements
- R1: For a channel with code c in 0..251, master mute inactive and the envelope at full gain, the output is the input multiplied by 2^-floor(c/24) · 10^(-(c mod 24)/80). The error is at most 1 LSB plus |input|/4096. Code 0 passes the input through unchanged. The codes of the two channels act independently.
- R2: A channel whose code is 252 or above (252 through 255) outputs 0, whatever the other channel's code is.
- R3: The envelope keeps a position p in 0..128. Each accepted sample uses the gain G(p). G(128) is 0, and for p below 128, G(p) = (1 + cos(π·floor(p/4)/32))/2. While master_mute is 1, each accepted sample then moves p up by one, stopping at 128.
- R4: While master_mute is 0, each accepted sample moves p down by one, stopping at 0. A reversal in mid-fade continues from the current p.
- R5: p moves only on cycles where in_valid is 1. master_mute has no effect on cycles without a sample.
- R6: When invert is 1, the output is the negated scaled value. Negating -8388608 gives +8388607.
- R7: For in_valid high in clock cycle n, out_valid is high in cycle n+2 and carries that sample's result. There is exactly one output strobe per accepted sample. The codes, master_mute and invert that apply to a sample are the ones present in the same cycle as its in_valid.
- R8: While out_valid is 0, out_left and out_right keep their last value, even if the codes or invert change.
- R9: Scaled results are rounded half toward positive infinity and clipped to the 24-bit signed range.
- R10: After reset, out_valid is 0, both outputs are 0 and p is 128 (fully muted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: a stereo sample is present this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| att_left | input | 8 | Left attenuation code, 0.25 dB per step, 252 and above mute |
| att_right | input | 8 | Right attenuation code, 0.25 dB per step, 252 and above mute |
| master_mute | input | 1 | 1 fades both channels out, 0 fades them in |
| invert | input | 1 | 1 negates both outputs |
| out_valid | output | 1 | Strobe: a scaled sample is present |
| out_left | output | 24 | Left result, two's complement |
| out_right | output | 24 | Right result, two's complement |

## Verification
Every result is due exactly two clock cycles after the cycle in which its sample is presented. The bench drives inputs on the falling edge and records each accepted sample in a history, so it knows which falling edge, two edges later, must show out_valid and the result. The behavioural model advances its own envelope position only on accepted samples, using the same-cycle mute request. On every falling edge the bench compares out_valid with the two-cycle-delayed strobe. It then either pops the expected value from the queue or checks that the outputs have held.

// File: rtl/svs_pkg.sv
package svs_pkg;

   // Gains are unsigned Q1.15; 1.0 is 2**GAIN_FRAC and needs GAIN_W bits.
   localparam int unsigned GAIN_FRAC = 15;
   localparam int unsigned GAIN_W    = GAIN_FRAC + 2;

   // Number of distinct levels in the cosine fade table.
   localparam int unsigned ENV_ENTRIES = 32;

   // Q30 helpers for building the tables at elaboration.
   localparam longint Q30_ONE  = 64'sd1073741824;
   localparam longint Q30_HALF = 64'sd536870912;
   localparam longint QDB_STEP = 64'sd1043277569;   // 10^(-0.25/20)
   localparam longint COS_STEP = 64'sd1068571464;   // cos(pi/32)
   localparam longint TWO_COS  = 64'sd2137142927;   // 2*cos(pi/32)

   function automatic logic [GAIN_W-1:0] to_q15(input longint v30);
      longint r;
      r = (v30 + 64'sd16384) >>> 15;
      return GAIN_W'(r);
   endfunction

   // Mantissa for 'step' quarter-dB steps of attenuation.
   function automatic logic [GAIN_W-1:0] quarter_db_mant(input int unsigned step);
      longint m;
      m = Q30_ONE;
      for (int unsigned i = 0; i < step; i++)
         m = (m * QDB_STEP + Q30_HALF) >>> 30;
      return to_q15(m);
   endfunction

   // Raised cosine (1 + cos(pi*idx/32)) / 2 via the Chebyshev recurrence.
   function automatic logic [GAIN_W-1:0] env_level(input int unsigned idx);
      longint c_prev, c_cur, c_next;
      c_prev = Q30_ONE;
      c_cur  = COS_STEP;
      if (idx == 0) begin
         c_cur = Q30_ONE;
      end else begin
         for (int unsigned i = 1; i < idx; i++) begin
            c_next = ((TWO_COS * c_cur + Q30_HALF) >>> 30) - c_prev;
            c_prev = c_cur;
            c_cur  = c_next;
         end
      end
      return to_q15((Q30_ONE + c_cur) >>> 1);
   endfunction

endpackage

// File: rtl/svs_envelope.sv
module svs_envelope
   import svs_pkg::*;
#(
   parameter int unsigned RAMP_LEN = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              mute_req,
   output logic [GAIN_W-1:0] env_gain
);
   localparam int unsigned IDX_W  = $clog2(RAMP_LEN + 1);
   localparam int unsigned REPEAT = RAMP_LEN / ENV_ENTRIES;
   localparam int unsigned SEL_W  = $clog2(ENV_ENTRIES);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(RAMP_LEN);

   logic [IDX_W-1:0]  idx_q;
   logic [SEL_W-1:0]  sel;
   logic [GAIN_W-1:0] shape [ENV_ENTRIES];

   for (genvar g = 0; g < ENV_ENTRIES; g++) begin : g_shape
      localparam logic [GAIN_W-1:0] LEVEL = env_level(g);
      assign shape[g] = LEVEL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= IDX_END;
      end else if (step) begin
         if (mute_req && idx_q != IDX_END)
            idx_q <= idx_q + 1'b1;
         else if (!mute_req && idx_q != '0)
            idx_q <= idx_q - 1'b1;
      end
   end

   always_comb begin
      sel = SEL_W'(32'(idx_q) / REPEAT);
      if (idx_q == IDX_END)
         env_gain = '0;
      else
         env_gain = shape[sel];
   end

   // R3: position never leaves 0..RAMP_LEN
   a_r3_env_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_END);

   // R3: a mute request climbs one position per accepted sample
   a_r3_mute_climbs: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mute_req && idx_q != IDX_END) |=> idx_q == $past(idx_q) + 1'b1);

   // R4: an unmute request descends one position per accepted sample
   a_r4_unmute_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mute_req && idx_q != '0) |=> idx_q == $past(idx_q) - 1'b1);

   // R5: no sample, no movement
   a_r5_env_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(idx_q));

endmodule

// File: rtl/svs_gain_calc.sv
module svs_gain_calc
   import svs_pkg::*;
#(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned MUTE_CODE = 252,
   parameter int unsigned STEPS     = 24,
   parameter int unsigned SEG_W     = 4
) (
   input  logic [CODE_W-1:0] code,
   input  logic [GAIN_W-1:0] env_gain,
   output logic [GAIN_W-1:0] gain,
   output logic [SEG_W-1:0]  seg
);
   localparam int unsigned SLOT_W = $clog2(STEPS);
   localparam int unsigned PROD_W = 2 * GAIN_W;
   localparam logic [PROD_W-1:0] RND = PROD_W'(1) << (GAIN_FRAC - 1);
   localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << GAIN_FRAC;

   logic [GAIN_W-1:0] mant [STEPS];
   logic [SLOT_W-1:0] slot;
   logic [PROD_W-1:0] prod;

   for (genvar g = 0; g < STEPS; g++) begin : g_mant
      localparam logic [GAIN_W-1:0] VAL = quarter_db_mant(g);
      assign mant[g] = VAL;
   end

   always_comb begin
      slot = SLOT_W'(32'(code) % STEPS);
      seg  = SEG_W'(32'(code) / STEPS);
      prod = PROD_W'(mant[slot]) * PROD_W'(env_gain) + RND;
      if (32'(code) >= MUTE_CODE)
         gain = '0;
      else
         gain = GAIN_W'(prod >> GAIN_FRAC);
   end

   always_comb begin
      // R2: a mute code always yields zero gain
      a_r2_mute_gain: assert (32'(code) < MUTE_CODE || gain == '0);
      // R1: combined gain never exceeds unity
      a_r1_gain_unity: assert (gain <= UNITY);
   end

endmodule

// File: rtl/svs_scaler.sv
module svs_scaler
   import svs_pkg::*;
#(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned SEG_W  = 4
) (
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [GAIN_W-1:0] gain,
   input  logic        [SEG_W-1:0]  seg,
   input  logic                     invert,
   output logic signed [DATA_W-1:0] result
);
   localparam int unsigned PW = DATA_W + GAIN_W + 1;
   localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [PW-1:0]     prod;
   logic signed [PW-1:0]     rounded;
   logic signed [DATA_W-1:0] clipped;
   int unsigned              sh;

   always_comb begin
      sh      = 32'(seg) + GAIN_FRAC;
      prod    = PW'(sample) * PW'($signed({1'b0, gain}));
      rounded = (prod + (PW'(1) <<< (sh - 1))) >>> sh;
      if (rounded > PW'(POS_MAX))
         clipped = POS_MAX;
      else if (rounded < PW'(NEG_MAX))
         clipped = NEG_MAX;
      else
         clipped = rounded[DATA_W-1:0];
      if (!invert)
         result = clipped;
      else if (clipped == NEG_MAX)
         result = POS_MAX;
      else
         result = -clipped;
   end

   always_comb begin
      // R9: without inversion the sign of the rounded product survives clipping
      a_r9_sign_kept: assert (invert || rounded < 0 || result >= 0);
      // R6: inversion turns a positive rounded value negative
      a_r6_sign_flip: assert (!invert || rounded <= 0 || result < 0);
   end

endmodule

// File: rtl/stereo_vol_softmute.sv
module stereo_vol_softmute
   import svs_pkg::*;
#(
   parameter int unsigned DATA_W          = 24,
   parameter int unsigned CODE_W          = 8,
   parameter int unsigned MUTE_CODE       = 252,
   parameter int unsigned STEPS_PER_SHIFT = 24,
   parameter int unsigned RAMP_LEN        = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   input  logic [CODE_W-1:0] att_left,
   input  logic [CODE_W-1:0] att_right,
   input  logic              master_mute,
   input  logic              invert,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_left,
   output logic [DATA_W-1:0] out_right
);
   localparam int unsigned MAX_SEG = ((1 << CODE_W) - 1) / STEPS_PER_SHIFT;
   localparam int unsigned SEG_W   = (MAX_SEG < 1) ? 1 : $clog2(MAX_SEG + 1);

   if (RAMP_LEN == 0 || RAMP_LEN % ENV_ENTRIES != 0) begin : g_bad_ramp
      $error("RAMP_LEN must be a non-zero multiple of the envelope table size");
   end
   if (MUTE_CODE >= (1 << CODE_W) || STEPS_PER_SHIFT < 2) begin : g_bad_code
      $error("MUTE_CODE must fit CODE_W and STEPS_PER_SHIFT must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [GAIN_W-1:0] env_gain;
   logic              v1_q;
   logic              inv1_q;
   logic              out_v_q;

   svs_envelope #(
      .RAMP_LEN (RAMP_LEN)
   ) i_envelope (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (in_valid),
      .mute_req (master_mute),
      .env_gain (env_gain)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic signed [DATA_W-1:0] samp_in;
      logic signed [DATA_W-1:0] s1_samp;
      logic signed [DATA_W-1:0] scaled;
      logic signed [DATA_W-1:0] out_q;
      logic        [CODE_W-1:0] code_in;
      logic        [GAIN_W-1:0] gain_c;
      logic        [GAIN_W-1:0] s1_gain;
      logic        [SEG_W-1:0]  seg_c;
      logic        [SEG_W-1:0]  s1_seg;

      if (ch == 0) begin : g_left
         assign samp_in  = in_left;
         assign code_in  = att_left;
         assign out_left = out_q;
      end else begin : g_right
         assign samp_in   = in_right;
         assign code_in   = att_right;
         assign out_right = out_q;
      end

      svs_gain_calc #(
         .CODE_W    (CODE_W),
         .MUTE_CODE (MUTE_CODE),
         .STEPS     (STEPS_PER_SHIFT),
         .SEG_W     (SEG_W)
      ) i_gain (
         .code     (code_in),
         .env_gain (env_gain),
         .gain     (gain_c),
         .seg      (seg_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_samp <= '0;
            s1_gain <= '0;
            s1_seg  <= '0;
         end else if (in_valid) begin
            s1_samp <= samp_in;
            s1_gain <= gain_c;
            s1_seg  <= seg_c;
         end
      end

      svs_scaler #(
         .DATA_W (DATA_W),
         .SEG_W  (SEG_W)
      ) i_scaler (
         .sample (s1_samp),
         .gain   (s1_gain),
         .seg    (s1_seg),
         .invert (inv1_q),
         .result (scaled)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            out_q <= '0;
         else if (v1_q)
            out_q <= scaled;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q    <= 1'b0;
         inv1_q  <= 1'b0;
         out_v_q <= 1'b0;
      end else begin
         v1_q    <= in_valid;
         out_v_q <= v1_q;
         if (in_valid)
            inv1_q <= invert;
      end
   end

   assign out_valid = out_v_q;

   // R7: every accepted sample produces a strobe two cycles later
   a_r7_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   // R7: no strobe without a sample two cycles earlier
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   // R8: outputs hold between results
   a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_left) && $stable(out_right)));

endmodule

// File: tb/test_stereo_vol_softmute.sv
module test_stereo_vol_softmute;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_left = '0;
   logic [23:0] in_right = '0;
   logic [7:0]  att_left = '0;
   logic [7:0]  att_right = '0;
   logic        master_mute = 1'b1;
   logic        invert = 1'b0;
   logic        out_valid;
   logic [23:0] out_left;
   logic [23:0] out_right;

   always #2 clk = ~clk;   // 250 MHz

   stereo_vol_softmute i_stereo_vol_softmute (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_left     (in_left),
      .in_right    (in_right),
      .att_left    (att_left),
      .att_right   (att_right),
      .master_mute (master_mute),
      .invert      (invert),
      .out_valid   (out_valid),
      .out_left    (out_left),
      .out_right   (out_right)
   );

   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   int    env_pos = 128;
   bit    vh0 = 1'b0;
   bit    vh1 = 1'b0;
   real   last_l = 0.0;
   real   last_r = 0.0;
   real   exp_l[$];
   real   exp_r[$];
   real   tol_l[$];
   real   tol_r[$];
   string tag_q[$];

   function automatic real env_shape(int p);
      if (p >= 128) return 0.0;
      return (1.0 + $cos(3.141592653589793 * real'(p / 4) / 32.0)) / 2.0;
   endfunction

   function automatic real atten(int code);
      if (code >= 252) return 0.0;
      return (2.0 ** (-real'(code / 24))) * (10.0 ** (-real'(code % 24) / 80.0));
   endfunction

   function automatic real model(int x, int code, int p, bit inv);
      real y;
      y = real'(x) * atten(code) * env_shape(p);
      if (inv) y = -y;
      if (y > 8388607.0) y = 8388607.0;
      if (y < -8388608.0) y = -8388608.0;
      return y;
   endfunction

   function automatic real tolerance(int x);
      return 1.0 + ((x < 0) ? -real'(x) : real'(x)) / 4096.0;
   endfunction

   task automatic check(string tag, string what, real act, real exp, real tol);
      checks++;
      if (act - exp > tol || exp - act > tol) begin
         failures++;
         $display("FAIL %s %s actual=%0f expected=%0f", tag, what, act, exp);
      end
   endtask

   // One clock: observe outputs, then drive the next inputs.
   task automatic tick(bit v, int xl, int xr, int cl, int cr, bit mm, bit inv, string tag);
      real al, ar;
      string t;
      @(negedge clk);
      al = real'($signed(out_left));
      ar = real'($signed(out_right));
      check("R7", "out_valid", real'(out_valid), real'(vh1), 0.0);
      if (vh1 && exp_l.size() > 0) begin
         t = tag_q.pop_front();
         check(t, "left", al, exp_l.pop_front(), tol_l.pop_front());
         check(t, "right", ar, exp_r.pop_front(), tol_r.pop_front());
         last_l = al;
         last_r = ar;
      end else if (!vh1) begin
         check("R8", "left held", al, last_l, 0.0);
         check("R8", "right held", ar, last_r, 0.0);
      end
      vh1 = vh0;
      vh0 = v;
      in_valid    = v;
      in_left     = xl[23:0];
      in_right    = xr[23:0];
      att_left    = cl[7:0];
      att_right   = cr[7:0];
      master_mute = mm;
      invert      = inv;
      if (v) begin
         exp_l.push_back(model(xl, cl, env_pos, inv));
         exp_r.push_back(model(xr, cr, env_pos, inv));
         tol_l.push_back(tolerance(xl));
         tol_r.push_back(tolerance(xr));
         tag_q.push_back(tag);
         if (mm && env_pos < 128) env_pos++;
         else if (!mm && env_pos > 0) env_pos--;
      end
   endtask

   function automatic int rnd24();
      return $signed($urandom) >>> 8;
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R7 watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int cl_tab[6];
      int cr_tab[6];
      cl_tab = '{0, 1, 100, 251, 23, 200};
      cr_tab = '{0, 24, 37, 0, 48, 5};

      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10", "out_valid in reset", real'(out_valid), 0.0, 0.0);
      check("R10", "left in reset", real'($signed(out_left)), 0.0, 0.0);
      check("R10", "right in reset", real'($signed(out_right)), 0.0, 0.0);
      rst_n = 1'b1;

      // R10: fully muted after reset
      for (int i = 0; i < 4; i++) tick(1, 1000000, -2000000, 0, 0, 1, 0, "R10");

      // R4: fade in from full mute
      for (int i = 0; i < 132; i++) tick(1, 4194304, -3000001, 0, 0, 0, 0, "R4");

      // R1: attenuation codes, independent per channel
      for (int k = 0; k < 6; k++)
         for (int i = 0; i < 6; i++)
            tick(1, rnd24(), rnd24(), cl_tab[k], cr_tab[k], 0, 0, "R1");

      // R2: mute codes 252..255
      for (int i = 0; i < 4; i++) tick(1, rnd24(), 3000000, 252, 0, 0, 0, "R2");
      for (int i = 0; i < 4; i++) tick(1, -3000000, rnd24(), 0, 253, 0, 0, "R2");
      for (int i = 0; i < 4; i++) tick(1, rnd24(), rnd24(), 255, 254, 0, 0, "R2");

      // R8: idle cycles with changing controls must not move the outputs
      for (int i = 0; i < 20; i++) tick(0, rnd24(), rnd24(), 80 + i, 3 * i, 1, i % 2, "R8");

      // R3 and R5: fade out, idle cycles in between request unmute
      for (int i = 0; i < 60; i++) begin
         tick(1, 6000000, -6000000, 0, 10, 1, 0, "R3");
         if (i % 3 == 0) tick(0, 0, 0, 0, 10, 0, 0, "R5");
      end

      // R4: reversal mid-fade
      for (int i = 0; i < 30; i++) tick(1, 6000000, -6000000, 0, 10, 0, 0, "R4");

      // R3: fade out fully and stay muted
      for (int i = 0; i < 140; i++) tick(1, 7000000, rnd24(), 0, 2, 1, 0, "R3");

      // R4: fade back in fully
      for (int i = 0; i < 130; i++) tick(1, -7000000, 5000000, 4, 0, 0, 0, "R4");

      // R6: polarity flip including the most negative value
      tick(1, 8388607, -8388608, 0, 0, 0, 1, "R6");
      tick(1, -8388608, 8388607, 0, 0, 0, 1, "R6");
      tick(1, 1234567, -5, 0, 30, 0, 1, "R6");
      for (int i = 0; i < 10; i++) tick(1, rnd24(), rnd24(), 7, 61, 0, 1, "R6");

      // R9: rounding and full-scale values
      tick(1, -8388608, 8388607, 0, 0, 0, 0, "R9");
      tick(1, 5, -5, 24, 24, 0, 0, "R9");
      tick(1, 3, -3, 48, 48, 0, 0, "R9");

      // drain the pipeline
      for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0, 0, 0, "R8");
      check("R7", "results outstanding", real'(exp_l.size()), 0.0, 0.0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule